// File: doc/BRIEF.md
# RS-485 Multidrop Receive Filter and Line-Direction Control

This block sits beside a UART's framing logic and adds the two pieces needed on a shared RS-485 bus. On the receive side, every character delivered by the framer carries a ninth bit in the slot a parity bit would normally use. A set ninth bit marks the character as a station address and a clear one marks it as data. A two-state machine (`RX_OFF`, `RX_ON`) decides whether each character goes into the receive FIFO. When a character is pushed, its ninth bit goes out in the FIFO entry's parity-error position, so software can tell addresses from data. A line-status interrupt request is raised for every pushed address.

Three receive modes are available. With multidrop off, every character is pushed. In manual multidrop mode, software owns the receiver-enable state and addresses are always pushed. In auto-address mode, the hardware compares each address with the programmed station address. A match moves the machine `RX_OFF -> RX_ON`. A mismatch while enabled moves it `RX_ON -> RX_OFF`, and the mismatching address is dropped. The host can write the enable state at any time through the host-write transition into either state.

On the transmit side, a three-state machine (`DIR_IDLE`, `DIR_LAUNCH`, `DIR_SEND`) drives the bus-direction (RTS) pin. A FIFO write moves `DIR_IDLE -> DIR_LAUNCH`. The first sign of transmitter activity moves `DIR_LAUNCH -> DIR_SEND`. A further write moves `DIR_SEND -> DIR_LAUNCH`. The return `DIR_SEND -> DIR_IDLE` happens once the transmit FIFO is empty and the shifter has finished its stop period. Turning auto-direction off forces `DIR_IDLE` from any state.

Top module: `rs485_ctrl`

## Requirements
- R1: On every push made in either multidrop mode, `push_aflag` equals the character's ninth bit (1 = address, 0 = data) and `push_data` equals the character.
- R2: With `mdrop_en`=0, every valid character is pushed with `push_aflag`=0, `lsr_irq` stays 0, and `rx_en` is unchanged.
- R3: In manual multidrop mode (`mdrop_en`=1, `auto_addr`=0) with the receiver off, data characters are dropped; address characters are pushed with the flag set, raise `lsr_irq`, and leave `rx_en` at 0.
- R4: In manual multidrop mode with the receiver on, every character is pushed and each address raises `lsr_irq`; `rx_en` stays 1.
- R5: In auto-address mode with the receiver off, data characters and addresses that differ from `station_addr` are dropped. An address equal to `station_addr` is pushed with the flag set, raises `lsr_irq`, and sets `rx_en` to 1.
- R6: In auto-address mode with the receiver on, data is pushed and a matching address is pushed with `lsr_irq` while `rx_en` stays 1. A non-matching address is dropped and clears `rx_en`.
- R7: A pulse on `host_rxen_wr` loads `host_rxen_val` into `rx_en` on the next edge. A character arriving in the same cycle is judged with the old enable state, and the host value wins as the new state.
- R8: `push_vld`, `push_data`, `push_aflag` and `lsr_irq` are registered: they appear one cycle after `rx_valid`, and each lasts one cycle per character.
- R9: With `auto_dir`=1, the cycle after a `txq_wr` pulse the RTS line is in its active level.
- R10: With `auto_dir`=1, the RTS line stays active until `tx_fifo_empty` and `tx_shift_idle` are both 1 with no new write. It returns to inactive on the following edge, and it never releases before transmitter activity has been seen after a write.
- R11: With `auto_dir`=1, the active level is low when `rts_invert`=0 and high when `rts_invert`=1; `manual_rts` and the flow-control inputs have no effect.
- R12: With `auto_dir`=0, `rts_invert` has no effect and `rts_n` = NOT(`hwfc_en` ? `hwfc_rts` : `manual_rts`).
- R13: After reset, `rx_en`=0, no push or interrupt is pending, and the direction machine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Framer delivers a character this cycle |
| rx_data | input | DATA_W | Received character |
| rx_bit9 | input | 1 | Ninth (parity-position) bit of the character |
| station_addr | input | DATA_W | Programmed station address |
| mdrop_en | input | 1 | Multidrop receive mode enable |
| auto_addr | input | 1 | Hardware address filtering enable |
| host_rxen_wr | input | 1 | Host write strobe for the receiver enable |
| host_rxen_val | input | 1 | Value written by the host |
| auto_dir | input | 1 | Transmitter-driven RTS enable |
| rts_invert | input | 1 | Reverse RTS polarity in auto-direction mode |
| manual_rts | input | 1 | Software RTS request (1 = assert) |
| hwfc_en | input | 1 | Hardware flow control owns RTS |
| hwfc_rts | input | 1 | Flow-control RTS request (1 = assert) |
| txq_wr | input | 1 | Host writes the transmit FIFO |
| tx_fifo_empty | input | 1 | Transmit FIFO holds nothing |
| tx_shift_idle | input | 1 | Shifter empty and stop period over |
| rx_en | output | 1 | Receiver-enable state |
| push_vld | output | 1 | Push qualifier for the receive FIFO |
| push_data | output | DATA_W | Character to push |
| push_aflag | output | 1 | Address flag, stored in the parity-error slot |
| lsr_irq | output | 1 | Line-status interrupt request pulse |
| rts_n | output | 1 | RTS pin level |

## Verification
The bench sweeps every mode against both starting enable states and three kinds of character: data, a matching address, and a non-matching address. The data character carries the same value as the station address. A design that compared values without checking the ninth bit would therefore wake on data, and one that ignored the enable in manual mode would push data it should drop. The same-cycle host write catches a design that lets the host value decide the current character, or that lets the character transition override the host. The direction checks hold `tx_fifo_empty` high for several cycles after a write. A design that released RTS on an empty FIFO alone, or before the shifter finished, would drop the line while a character is still going out. All 32 combinations of the polarity and source controls are swept to catch an inversion that leaks into manual mode.

// File: rtl/rs485_pkg.sv
package rs485_pkg;

    typedef enum logic {
        RX_OFF = 1'b0,
        RX_ON  = 1'b1
    } rx_state_t;

    typedef enum logic [1:0] {
        DIR_IDLE   = 2'd0,
        DIR_LAUNCH = 2'd1,
        DIR_SEND   = 2'd2
    } dir_state_t;

    typedef struct packed {
        logic push;
        logic flag;
        logic irq;
    } rx_verdict_t;

endpackage

// File: rtl/rs485_rx_filter.sv
module rs485_rx_filter
    import rs485_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_bit9,
    input  logic [DATA_W-1:0] station_addr,
    input  logic              mdrop_en,
    input  logic              auto_addr,
    input  logic              host_rxen_wr,
    input  logic              host_rxen_val,
    output logic              rx_en,
    output logic              push_vld,
    output logic [DATA_W-1:0] push_data,
    output logic              push_aflag,
    output logic              lsr_irq
);

    rx_state_t   state_q, state_d;
    rx_verdict_t verdict;
    logic        addr_hit;

    assign addr_hit = rx_bit9 && (rx_data == station_addr);

    // next state and per-character verdict
    always_comb begin
        state_d = state_q;
        verdict = '0;
        if (rx_valid) begin
            if (!mdrop_en) begin
                verdict.push = 1'b1;
            end else begin
                unique case (state_q)
                    RX_OFF: begin
                        if (rx_bit9) begin
                            if (!auto_addr || addr_hit) begin
                                verdict = '{push: 1'b1, flag: 1'b1, irq: 1'b1};
                                if (auto_addr) state_d = RX_ON;
                            end
                        end
                    end
                    RX_ON: begin
                        if (!rx_bit9) begin
                            verdict.push = 1'b1;
                        end else if (!auto_addr || addr_hit) begin
                            verdict = '{push: 1'b1, flag: 1'b1, irq: 1'b1};
                        end else begin
                            state_d = RX_OFF;
                        end
                    end
                    default: state_d = RX_OFF;
                endcase
            end
        end
        if (host_rxen_wr) begin
            state_d = host_rxen_val ? RX_ON : RX_OFF;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_OFF;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push_vld   <= 1'b0;
            push_data  <= '0;
            push_aflag <= 1'b0;
            lsr_irq    <= 1'b0;
        end else begin
            push_vld   <= verdict.push;
            push_data  <= rx_data;
            push_aflag <= verdict.flag;
            lsr_irq    <= verdict.irq;
        end
    end

    assign rx_en = (state_q == RX_ON);

    // R1
    aflag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_vld && push_aflag) |-> ($past(rx_bit9) && $past(mdrop_en)));

    // R3
    irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_irq |-> (push_vld && push_aflag));

    // R5
    data_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mdrop_en && !rx_bit9 && !rx_en) |=> !push_vld);

    // R8
    push_needs_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_vld |-> $past(rx_valid));

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_dir,
    input  logic rts_invert,
    input  logic manual_rts,
    input  logic hwfc_en,
    input  logic hwfc_rts,
    input  logic txq_wr,
    input  logic tx_fifo_empty,
    input  logic tx_shift_idle,
    output logic rts_n
);

    dir_state_t state_q, state_d;
    logic       drive_active;
    logic       tx_drained;
    logic       host_req;

    assign tx_drained = tx_fifo_empty && tx_shift_idle;

    always_comb begin
        state_d = state_q;
        if (!auto_dir) begin
            state_d = DIR_IDLE;
        end else begin
            unique case (state_q)
                DIR_IDLE:   if (txq_wr) state_d = DIR_LAUNCH;
                DIR_LAUNCH: if (!tx_drained) state_d = DIR_SEND;
                DIR_SEND: begin
                    if (txq_wr)          state_d = DIR_LAUNCH;
                    else if (tx_drained) state_d = DIR_IDLE;
                end
                default:    state_d = DIR_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DIR_IDLE;
        else        state_q <= state_d;
    end

    // pin level
    always_comb begin
        drive_active = (state_q != DIR_IDLE);
        host_req     = hwfc_en ? hwfc_rts : manual_rts;
        if (auto_dir) rts_n = rts_invert ? drive_active : ~drive_active;
        else          rts_n = ~host_req;
    end

    // R9
    wr_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_dir && txq_wr) |=> (drive_active || !auto_dir));

    // R10
    release_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drive_active) && $past(auto_dir)) |-> $past(tx_drained && !txq_wr));

endmodule

// File: rtl/rs485_ctrl.sv
module rs485_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_bit9,
    input  logic [DATA_W-1:0] station_addr,
    input  logic              mdrop_en,
    input  logic              auto_addr,
    input  logic              host_rxen_wr,
    input  logic              host_rxen_val,
    input  logic              auto_dir,
    input  logic              rts_invert,
    input  logic              manual_rts,
    input  logic              hwfc_en,
    input  logic              hwfc_rts,
    input  logic              txq_wr,
    input  logic              tx_fifo_empty,
    input  logic              tx_shift_idle,
    output logic              rx_en,
    output logic              push_vld,
    output logic [DATA_W-1:0] push_data,
    output logic              push_aflag,
    output logic              lsr_irq,
    output logic              rts_n
);

    rs485_rx_filter #(.DATA_W(DATA_W)) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_bit9       (rx_bit9),
        .station_addr  (station_addr),
        .mdrop_en      (mdrop_en),
        .auto_addr     (auto_addr),
        .host_rxen_wr  (host_rxen_wr),
        .host_rxen_val (host_rxen_val),
        .rx_en         (rx_en),
        .push_vld      (push_vld),
        .push_data     (push_data),
        .push_aflag    (push_aflag),
        .lsr_irq       (lsr_irq)
    );

    rs485_dir_ctrl u_dir (
        .clk           (clk),
        .rst_n         (rst_n),
        .auto_dir      (auto_dir),
        .rts_invert    (rts_invert),
        .manual_rts    (manual_rts),
        .hwfc_en       (hwfc_en),
        .hwfc_rts      (hwfc_rts),
        .txq_wr        (txq_wr),
        .tx_fifo_empty (tx_fifo_empty),
        .tx_shift_idle (tx_shift_idle),
        .rts_n         (rts_n)
    );

endmodule

// File: tb/rs485_ctrl_tb.sv
`timescale 1ns/1ps
module rs485_ctrl_tb;

    localparam int DW = 8;
    localparam logic [DW-1:0] STN = 8'hA7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_valid = 0, rx_bit9 = 0, mdrop_en = 0, auto_addr = 0;
    logic host_rxen_wr = 0, host_rxen_val = 0;
    logic auto_dir = 0, rts_invert = 0, manual_rts = 0, hwfc_en = 0, hwfc_rts = 0;
    logic txq_wr = 0, tx_fifo_empty = 1, tx_shift_idle = 1;
    logic [DW-1:0] rx_data = '0;
    logic [DW-1:0] station_addr = STN;
    logic rx_en, push_vld, push_aflag, lsr_irq, rts_n;
    logic [DW-1:0] push_data;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rs485_ctrl #(.DATA_W(DW)) u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_set(input logic v);
        @(negedge clk); host_rxen_wr = 1; host_rxen_val = v;
        @(negedge clk); host_rxen_wr = 0;
    endtask

    task automatic send(input logic [DW-1:0] d, input logic b9);
        @(negedge clk); rx_valid = 1; rx_data = d; rx_bit9 = b9;
        @(negedge clk); rx_valid = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 rx_en", rx_en, 0);
        chk("R13 push", push_vld, 0);
        chk("R13 irq", lsr_irq, 0);
        chk("R13 rts", rts_n, 1);
        rst_n = 1;
        @(negedge clk);

        // receive sweep: mode 0 off, 1 manual, 2 auto
        for (int mode = 0; mode < 3; mode++) begin
            for (int en0 = 0; en0 < 2; en0++) begin
                for (int kind = 0; kind < 3; kind++) begin
                    logic [DW-1:0] d;
                    logic b9, hit;
                    int ep, ef, ei, en1;
                    string rq;
                    mdrop_en  = (mode != 0);
                    auto_addr = (mode == 2);
                    host_set(en0[0]);
                    chk("R7 host write", rx_en, en0);
                    d   = (kind == 2) ? (STN ^ 8'h5A) : STN;
                    b9  = (kind != 0);
                    hit = (kind == 1);
                    rq  = (mode == 0) ? "R2" : (mode == 1) ? (en0 ? "R4" : "R3")
                                     : (en0 ? "R6" : "R5");
                    en1 = en0; ep = 0; ef = 0; ei = 0;
                    if (mode == 0) ep = 1;
                    else if (!b9) ep = en0;
                    else if (mode == 1 || hit) begin
                        ep = 1; ef = 1; ei = 1;
                        if (mode == 2) en1 = 1;
                    end else en1 = 0;
                    send(d, b9);
                    chk({rq, " push"}, push_vld, ep);
                    chk({rq, " irq"}, lsr_irq, ei);
                    chk({rq, " rx_en"}, rx_en, en1);
                    if (ep == 1) begin
                        chk("R1 flag", push_aflag, ef);
                        chk("R1 data", push_data, d);
                    end
                    @(negedge clk);
                    chk("R8 push one cycle", push_vld, 0);
                    chk("R8 irq one cycle", lsr_irq, 0);
                end
            end
        end

        // R7 same-cycle host write with character
        mdrop_en = 1; auto_addr = 1;
        host_set(1'b0);
        @(negedge clk); rx_valid = 1; rx_data = STN; rx_bit9 = 1;
        host_rxen_wr = 1; host_rxen_val = 0;
        @(negedge clk); rx_valid = 0; host_rxen_wr = 0;
        chk("R7 old state judges match", push_vld, 1);
        chk("R7 host wins state", rx_en, 0);
        host_set(1'b1);
        @(negedge clk); rx_valid = 1; rx_data = 8'h11; rx_bit9 = 0;
        host_rxen_wr = 1; host_rxen_val = 0;
        @(negedge clk); rx_valid = 0; host_rxen_wr = 0;
        chk("R7 old state pushes data", push_vld, 1);
        chk("R7 host clears", rx_en, 0);

        // direction control, both polarities
        for (int inv = 0; inv < 2; inv++) begin
            int act_lvl, idle_lvl;
            act_lvl = inv; idle_lvl = 1 - inv;
            auto_dir = 1; rts_invert = inv[0]; manual_rts = 1;
            @(negedge clk);
            chk("R11 idle level", rts_n, idle_lvl);
            txq_wr = 1;
            @(negedge clk); txq_wr = 0;
            chk("R9 active after write", rts_n, act_lvl);
            repeat (3) @(negedge clk);
            chk("R10 held before activity", rts_n, act_lvl);
            tx_fifo_empty = 0; tx_shift_idle = 0;
            repeat (3) @(negedge clk);
            tx_fifo_empty = 1;
            repeat (2) @(negedge clk);
            chk("R10 held while shifting", rts_n, act_lvl);
            txq_wr = 1; tx_shift_idle = 1;
            @(negedge clk); txq_wr = 0;
            chk("R10 held on new write", rts_n, act_lvl);
            tx_fifo_empty = 0; tx_shift_idle = 0;
            @(negedge clk); tx_fifo_empty = 1; tx_shift_idle = 1;
            #1 chk("R10 not before edge", rts_n, act_lvl);
            @(negedge clk);
            chk("R10 released", rts_n, idle_lvl);
        end

        // polarity and source sweep
        for (int v = 0; v < 32; v++) begin
            int e;
            @(negedge clk);
            auto_dir = v[4]; rts_invert = v[3]; manual_rts = v[2];
            hwfc_en = v[1]; hwfc_rts = v[0];
            #1;
            if (v[4]) e = v[3] ? 0 : 1;
            else      e = v[1] ? (1 - v[0]) : (1 - v[2]);
            chk(v[4] ? "R11 sweep" : "R12 sweep", rts_n, e);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule